// File: doc/BRIEF.md
# Channel-Gain List Scan Sequencer

This block is the register-side sequencing logic for a multi-channel A/D front end. Software programs a list of up to sixteen channel/gain pairs through a word-wide register write port. The block then walks that list, one step per conversion, and drives a mux channel select and a gain code toward the analog path. Conversions are started by software trigger commands. The converter is modelled inside the block as a fixed latency that ends in a result capture from the `adc_sample` input.

Loading works as follows. Software sets an enable bit in the list-control register, writes the A/D control register once per entry, and then clears the enable bit. A preload command points the sequencer at the first entry. It holds a mux-busy status until that entry has settled on the mux outputs. Each completed conversion sets a done flag. It also latches the result and advances the list pointer, which wraps to the first entry after the last one and signals the wrap with a one-cycle scan-done pulse. Reading the result clears the done flag. A trigger that arrives while done is still set counts as an overrun and sets the sticky error flag. An init command returns the pointer to the start and clears the flags. It keeps the list.

Register select on `reg_sel`: 0 = A/D control, 1 = list control, 2 = command, 3 = no register (write ignored).

Top module: `cgl_scan_seq`

## Requirements
- R1: After reset, `status`, `data_out`, `mux_chan`, `gain_code`, `irq` and `scan_done` are all zero.
- R2: A list-control write (select 1) with bit 15 set resets the append position to entry 0. It also sets the list length to bits 3:0 plus one. Every A/D control write (select 0) made while bit 15 is set stores one entry and moves to the next position. The entry's channel comes from bits 3:0 and its gain from bits 5:4. A list-control write with bit 15 clear ends loading and sets the length from its bits 3:0.
- R3: A command write (select 2) with bit 0 set is a preload. It moves the list pointer to entry 0 and raises mux-busy (status bit 8) for SETTLE_CYC cycles. Mux-busy clears on the same edge at which entry 0 appears on `mux_chan`/`gain_code`.
- R4: A command write with bit 1 set is a trigger. It starts a conversion when mux-busy is low and no conversion is in flight. Done (status bit 7) rises CONV_LAT clock edges after the write edge, and `data_out` takes `adc_sample` at that same edge.
- R5: Each completed conversion advances the list pointer and wraps from the last programmed entry to entry 0. The newly selected entry appears on the mux outputs two edges after done rises. `scan_done` pulses for one cycle together with the rise of done when the completed entry was the last one.
- R6: A one-cycle `data_rd` pulse clears done at the next edge.
- R7: The done-interrupt enable is status bit 6. It is taken from bit 6 of every A/D control write. `irq` is high exactly while both done and the enable are set.
- R8: A trigger that is accepted while done is still set sets the error flag (status bit 15). The flag stays set until an init command.
- R9: A command write with bit 2 set is an init. It resets the list pointer to entry 0, clears done, error and mux-busy, and cancels any conversion in flight. The list contents and length are kept. Init overrides any other command bit in the same write.
- R10: A trigger that arrives while mux-busy is high, or while a conversion is in flight, is ignored. No done and no pointer step results from it.
- R11: An A/D control write with loading disabled leaves the list contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 A/D control, 1 list control, 2 command) |
| reg_wdata | input | 16 | Register write data |
| data_rd | input | 1 | Result-register read strobe |
| adc_sample | input | 16 | Converter result, captured at conversion end |
| mux_chan | output | 4 | Mux channel of the current list entry |
| gain_code | output | 2 | Gain code of the current list entry |
| status | output | 16 | Status word: bit 15 error, bit 8 mux-busy, bit 7 done, bit 6 interrupt enable |
| data_out | output | 16 | Last captured conversion result |
| irq | output | 1 | Conversion-done interrupt request |
| scan_done | output | 1 | One-cycle pulse when the list wraps |

## Verification
Each result has a fixed cycle at which it is due. Mux-busy is high from the preload write edge for SETTLE_CYC edges. Done and the new data appear CONV_LAT edges after the trigger write edge, and scan-done pulses at that same edge. The next list entry reaches the mux two edges later. Done clears one edge after a read, and the error and init effects show one edge after their command. The bench drives and samples on falling edges. It counts exactly those edges from each write, and it checks the cycle before each transition as well as the cycle of the transition, so that an early or late output is caught.

// File: rtl/cgl_pkg.sv
package cgl_pkg;
  localparam int CHAN_W = 4;
  localparam int GAIN_W = 2;

  // register select codes
  localparam logic [1:0] SEL_ADCTL   = 2'd0;
  localparam logic [1:0] SEL_LISTCTL = 2'd1;
  localparam logic [1:0] SEL_CMD     = 2'd2;

  // field positions in written words
  localparam int CHAN_LSB    = 0;
  localparam int GAIN_LSB    = 4;
  localparam int IE_BIT      = 6;
  localparam int LOAD_EN_BIT = 15;

  // command bits
  localparam int CMD_PRELOAD = 0;
  localparam int CMD_TRIG    = 1;
  localparam int CMD_INIT    = 2;

  // status bits
  localparam int ST_ERR  = 15;
  localparam int ST_BUSY = 8;
  localparam int ST_DONE = 7;
  localparam int ST_IE   = 6;

  typedef struct packed {
    logic [GAIN_W-1:0] gain;
    logic [CHAN_W-1:0] chan;
  } cgl_entry_t;
endpackage

// File: rtl/cgl_list_ram.sv
module cgl_list_ram #(
  parameter int WIDTH  = 6,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cgl_countdown.sv
module cgl_countdown #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic fire
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign fire = busy_q && (cnt_q == '0);
endmodule

// File: rtl/cgl_scan_seq.sv
module cgl_scan_seq
  import cgl_pkg::*;
#(
  parameter int LEN_W      = 4,
  parameter int REG_W      = 16,
  parameter int SETTLE_CYC = 4,
  parameter int CONV_LAT   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              data_rd,
  input  logic [REG_W-1:0]  adc_sample,
  output logic [CHAN_W-1:0] mux_chan,
  output logic [GAIN_W-1:0] gain_code,
  output logic [REG_W-1:0]  status,
  output logic [REG_W-1:0]  data_out,
  output logic              irq,
  output logic              scan_done
);
  localparam int ENT_W = $bits(cgl_entry_t);

  // decoded writes
  logic wr_adctl, wr_listctl, wr_cmd;
  logic cmd_init, cmd_pre, cmd_trig;
  assign wr_adctl   = reg_we && (reg_sel == SEL_ADCTL);
  assign wr_listctl = reg_we && (reg_sel == SEL_LISTCTL);
  assign wr_cmd     = reg_we && (reg_sel == SEL_CMD);
  assign cmd_init   = wr_cmd && reg_wdata[CMD_INIT];
  assign cmd_pre    = wr_cmd && reg_wdata[CMD_PRELOAD] && !reg_wdata[CMD_INIT];
  assign cmd_trig   = wr_cmd && reg_wdata[CMD_TRIG] && !reg_wdata[CMD_INIT];

  // list programming state
  logic             load_en_q;
  logic [LEN_W-1:0] len_m1_q;
  logic [LEN_W-1:0] wr_idx_q;
  logic [LEN_W-1:0] ptr_q;
  logic             ram_we;
  cgl_entry_t       ram_wentry;
  logic [ENT_W-1:0] ram_rdata;
  cgl_entry_t       cur_entry;

  assign ram_we           = wr_adctl && load_en_q;
  assign ram_wentry.chan  = reg_wdata[CHAN_LSB +: CHAN_W];
  assign ram_wentry.gain  = reg_wdata[GAIN_LSB +: GAIN_W];
  assign cur_entry        = cgl_entry_t'(ram_rdata);

  cgl_list_ram #(.WIDTH(ENT_W), .ADDR_W(LEN_W)) u_list (
    .clk   (clk),
    .we    (ram_we),
    .waddr (wr_idx_q),
    .wdata (ram_wentry),
    .raddr (ptr_q),
    .rdata (ram_rdata)
  );

  // settle timer for preload, latency timer for the converter model
  logic settle_busy, settle_fire;
  logic conv_busy, conv_fire, conv_start;

  assign conv_start = cmd_trig && !settle_busy && !conv_busy;

  cgl_countdown #(.CYCLES(SETTLE_CYC)) u_settle (
    .clk   (clk),
    .rst   (rst),
    .start (cmd_pre),
    .abort (cmd_init),
    .busy  (settle_busy),
    .fire  (settle_fire)
  );

  cgl_countdown #(.CYCLES(CONV_LAT)) u_conv (
    .clk   (clk),
    .rst   (rst),
    .start (conv_start),
    .abort (cmd_init),
    .busy  (conv_busy),
    .fire  (conv_fire)
  );

  // status flags
  logic done_q, err_q, ie_q, irq_q;
  logic done_d, err_d, ie_d;
  logic [REG_W-1:0] data_q;
  logic adv_d1, adv_d2, scan_q;
  logic [CHAN_W-1:0] chan_q;
  logic [GAIN_W-1:0] gain_q;
  logic complete, at_last, apply;

  assign complete = conv_fire && !cmd_init;
  assign at_last  = (ptr_q == len_m1_q);
  assign apply    = (settle_fire && !cmd_init) || adv_d2;

  always_comb begin
    done_d = done_q;
    if (data_rd)  done_d = 1'b0;
    if (complete) done_d = 1'b1;
    if (cmd_init) done_d = 1'b0;

    err_d = err_q;
    if (conv_start && done_q) err_d = 1'b1;
    if (cmd_init)             err_d = 1'b0;

    ie_d = wr_adctl ? reg_wdata[IE_BIT] : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_en_q <= 1'b0;
      len_m1_q  <= '0;
      wr_idx_q  <= '0;
      ptr_q     <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      ie_q      <= 1'b0;
      irq_q     <= 1'b0;
      data_q    <= '0;
      adv_d1    <= 1'b0;
      adv_d2    <= 1'b0;
      scan_q    <= 1'b0;
      chan_q    <= '0;
      gain_q    <= '0;
    end else begin
      if (wr_listctl) begin
        load_en_q <= reg_wdata[LOAD_EN_BIT];
        len_m1_q  <= reg_wdata[LEN_W-1:0];
        if (reg_wdata[LOAD_EN_BIT]) wr_idx_q <= '0;
      end else if (ram_we) begin
        wr_idx_q <= wr_idx_q + 1'b1;
      end

      if (cmd_init || cmd_pre) ptr_q <= '0;
      else if (complete)       ptr_q <= at_last ? '0 : ptr_q + 1'b1;

      done_q <= done_d;
      err_q  <= err_d;
      ie_q   <= ie_d;
      irq_q  <= done_d && ie_d;

      if (complete) data_q <= adc_sample;

      adv_d1 <= complete;
      adv_d2 <= adv_d1;
      scan_q <= complete && at_last;

      if (apply) begin
        chan_q <= cur_entry.chan;
        gain_q <= cur_entry.gain;
      end
    end
  end

  always_comb begin
    status          = '0;
    status[ST_ERR]  = err_q;
    status[ST_BUSY] = settle_busy;
    status[ST_DONE] = done_q;
    status[ST_IE]   = ie_q;
  end

  assign mux_chan  = chan_q;
  assign gain_code = gain_q;
  assign data_out  = data_q;
  assign irq       = irq_q;
  assign scan_done = scan_q;
endmodule

// File: rtl/cgl_scan_seq_chk.sv
module cgl_scan_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_we,
  input logic [1:0]  reg_sel,
  input logic [15:0] reg_wdata,
  input logic        data_rd,
  input logic [15:0] status,
  input logic        irq,
  input logic        scan_done,
  input logic        conv_busy,
  input logic        conv_fire
);
  logic is_cmd;
  assign is_cmd = reg_we && (reg_sel == 2'd2);

  // R3
  preload_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (is_cmd && reg_wdata[0] && !reg_wdata[2]) |=> status[8]);

  // R5
  scan_done_chk: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> status[7]);

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !conv_fire) |=> !status[7]);

  // R7
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (status[6] && status[7]));

  // R8
  overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (is_cmd && reg_wdata[1] && !reg_wdata[2] && status[7] && !status[8] && !conv_busy)
    |=> status[15]);

  // R9
  init_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (is_cmd && reg_wdata[2]) |=> (!status[7] && !status[15] && !status[8] && !conv_busy));

  // R10
  ignore_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (is_cmd && reg_wdata[1] && status[8] && !conv_busy) |=> !conv_busy);
endmodule

bind cgl_scan_seq cgl_scan_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .data_rd   (data_rd),
  .status    (status),
  .irq       (irq),
  .scan_done (scan_done),
  .conv_busy (conv_busy),
  .conv_fire (conv_fire)
);

// File: tb/cgl_scan_seq_bench.sv
module cgl_scan_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 4;
  localparam int LAT    = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd3;
  logic [15:0] reg_wdata = '0;
  logic        data_rd = 1'b0;
  logic [15:0] adc_sample = '0;
  logic [3:0]  mux_chan;
  logic [1:0]  gain_code;
  logic [15:0] status;
  logic [15:0] data_out;
  logic        irq;
  logic        scan_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  cgl_scan_seq #(.SETTLE_CYC(SETTLE), .CONV_LAT(LAT)) u_cgl_scan_seq (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .data_rd(data_rd), .adc_sample(adc_sample),
    .mux_chan(mux_chan), .gain_code(gain_code), .status(status),
    .data_out(data_out), .irq(irq), .scan_done(scan_done)
  );

  int nchk = 0;
  int nfail = 0;
  logic [5:0] exp_list [16];
  int exp_len = 1;
  int exp_ptr = 0;
  logic cur_ie = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_sel = 2'd3;
  endtask

  function automatic logic [15:0] ctl_word(input logic [5:0] ent, input logic ie);
    return {9'd0, ie, ent};
  endfunction

  task automatic load_list(input int n);
    wr(2'd1, 16'h8000 | 16'(n - 1));
    for (int i = 0; i < n; i++) begin
      exp_list[i] = 6'($urandom());
      wr(2'd0, ctl_word(exp_list[i], cur_ie));
    end
    wr(2'd1, 16'(n - 1));
    exp_len = n;
  endtask

  task automatic preload_chk;
    wr(2'd2, 16'h0001);
    chk("R3 busy after preload", 32'(status[8]), 1);
    repeat (SETTLE - 1) @(negedge clk);
    chk("R3 busy last cycle", 32'(status[8]), 1);
    @(negedge clk);
    chk("R3 busy cleared", 32'(status[8]), 0);
    chk("R3 entry0 on mux", {26'd0, gain_code, mux_chan}, 32'(exp_list[0]));
    exp_ptr = 0;
  endtask

  task automatic convert(input logic [15:0] smp, input logic do_read);
    logic last;
    adc_sample = smp;
    last = (exp_ptr == exp_len - 1);
    wr(2'd2, 16'h0002);
    repeat (LAT - 1) @(negedge clk);
    chk("R4 done not early", 32'(status[7]), 0);
    @(negedge clk);
    chk("R4 done on time", 32'(status[7]), 1);
    chk("R4 data captured", 32'(data_out), 32'(smp));
    chk("R5 scan_done pulse", 32'(scan_done), 32'(last));
    chk("R7 irq follows enable", 32'(irq), 32'(cur_ie));
    exp_ptr = (exp_ptr + 1) % exp_len;
    @(negedge clk);
    chk("R5 scan_done one cycle", 32'(scan_done), 0);
    @(negedge clk);
    chk("R5 next entry on mux", {26'd0, gain_code, mux_chan}, 32'(exp_list[exp_ptr]));
    if (do_read) begin
      data_rd = 1'b1;
      @(negedge clk);
      data_rd = 1'b0;
      chk("R6 read clears done", 32'(status[7]), 0);
      chk("R7 irq low after read", 32'(irq), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 status", 32'(status), 0);
    chk("R1 mux", {26'd0, gain_code, mux_chan}, 0);
    chk("R1 data", 32'(data_out), 0);
    chk("R1 irq/scan", {30'd0, irq, scan_done}, 0);

    // R2 R4 R5 R6 R7: random lists, lengths 1 and 16 directed
    for (int r = 0; r < 6; r++) begin
      int n;
      n = (r == 0) ? 1 : (r == 1) ? 16 : 1 + int'($urandom() % 16);
      cur_ie = r[0];
      load_list(n);
      chk("R7 enable in status", 32'(status[6]), 32'(cur_ie));
      preload_chk();
      for (int k = 0; k < n + 2; k++) convert(16'($urandom()), 1'b1);
    end

    // R11: write with loading disabled must not alter entry 0
    wr(2'd0, ctl_word(~exp_list[0], cur_ie));
    preload_chk();

    // R10: trigger during mux-busy is dropped
    wr(2'd2, 16'h0001);
    wr(2'd2, 16'h0002);
    repeat (SETTLE + LAT + 3) @(negedge clk);
    chk("R10 no done from busy trigger", 32'(status[7]), 0);
    chk("R10 pointer unchanged", {26'd0, gain_code, mux_chan}, 32'(exp_list[0]));
    exp_ptr = 0;

    // R10: second trigger during a conversion is dropped
    adc_sample = 16'h1234;
    wr(2'd2, 16'h0002);
    wr(2'd2, 16'h0002);
    repeat (LAT + 4) @(negedge clk);
    exp_ptr = (exp_ptr + 1) % exp_len;
    chk("R10 single step", {26'd0, gain_code, mux_chan}, 32'(exp_list[exp_ptr]));
    chk("R10 no overrun", 32'(status[15]), 0);

    // R8: trigger while done set
    wr(2'd2, 16'h0002);
    chk("R8 error set", 32'(status[15]), 1);
    repeat (LAT + 3) @(negedge clk);
    chk("R8 error sticky", 32'(status[15]), 1);

    // R9: init clears flags, keeps list, pointer to 0
    wr(2'd2, 16'h0007);
    chk("R9 flags cleared", 32'(status & 16'h8180), 0);
    exp_ptr = 0;
    convert(16'hBEEF, 1'b1);
    preload_chk();
    chk("R9 list kept", {26'd0, gain_code, mux_chan}, 32'(exp_list[0]));

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule